// File: doc/BRIEF.md
# Recentering Elastic Receive Buffer

This block sits behind the character decoder of a serial receiver. Every cycle of the recovered clock it takes one decoded character: an 8-bit value plus three flags that mark it as an IDLE fill character, a K (control) character, or a character that failed decoding. It hands those characters out, one per cycle, on an independent word clock. A 16-entry circular store between the two clock domains absorbs phase wander. Write and read pointers cross between the domains as Gray code through two-flop synchronizers.

When the two clocks are not frequency-locked, the buffer keeps its fill near the middle by working on IDLE characters only. An IDLE that arrives while the store is nearly full is not stored. When the store is nearly empty and the character at the read head is IDLE, the read side presents that IDLE a second time. Link bring-up events recenter the buffer: a comma that moved the framing boundary, or the sync point of a word sync sequence, reported as single-cycle pulses in the write domain. A domain reset also recenters. A recenter may drop or repeat whatever the store held, so it is meant only for initialisation. Three single-cycle pulses on the read side report each insertion, each deletion and each recenter.

Top module: `elastic_rx_buffer`

## Requirements
- R1: Every stored entry keeps all 11 bits of a character (8-bit value, idle flag, K flag, error flag), and a delivered character carries the same four fields it was written with.
- R2: While either reset is low, and right after release, the outputs show an IDLE character (value 0x00, idle=1, K=0, error=0) with all three pulses low. The write pointer starts 8 entries ahead of the read pointer.
- R3: Characters with idle=0 (data, K or errored) leave the buffer exactly once and in write order. Only idle=1 characters are ever dropped or repeated.
- R4: An incoming IDLE is not stored when the write side's fill estimate (write pointer minus synchronised read pointer) exceeds 12. Each such deletion produces exactly one one-cycle del_pulse on the read side.
- R5: When the read side's fill estimate is below 4 and the head character is IDLE, the read pointer holds for one cycle. That IDLE is output a second time, and ins_pulse is high in the same cycle as the repeated IDLE.
- R6: Two insertions are at least 4 read cycles apart, and two deletions are at least 4 write cycles apart.
- R7: A one-cycle pulse on comma_realign causes exactly one recenter_pulse. The output character in that cycle is IDLE, and no insertion is reported with it.
- R8: A one-cycle pulse on sync_point causes exactly one recenter in the same way. The read pointer is placed 8 entries behind the synchronised write pointer, and lossless delivery of non-IDLE characters resumes afterwards.
- R9: With a write clock about 5 % faster or about 6 % slower than the read clock, and at least one IDLE in every three characters, no non-IDLE character is lost, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock; write domain |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| in_data | input | 8 | Decoded character value |
| in_idle | input | 1 | Character is an IDLE fill character |
| in_kchar | input | 1 | Character is a K (control) character |
| in_err | input | 1 | Character failed decoding |
| comma_realign | input | 1 | One-cycle pulse: a comma moved the framing boundary |
| sync_point | input | 1 | One-cycle pulse: word sync sequence sync point seen |
| rd_clk | input | 1 | Selected word clock; read domain |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| out_data | output | 8 | Delivered character value |
| out_idle | output | 1 | Delivered character is IDLE |
| out_kchar | output | 1 | Delivered character is a K character |
| out_err | output | 1 | Delivered character is errored |
| ins_pulse | output | 1 | One-cycle pulse: an extra IDLE is being output |
| del_pulse | output | 1 | One-cycle pulse: an incoming IDLE was dropped |
| recenter_pulse | output | 1 | One-cycle pulse: the read pointer was recentered |

## Verification
The hardest situation to reach is a sustained run of rate-matching decisions in one direction, with the fill estimates on both sides lagging behind the real fill. With equal clocks the thresholds are never crossed, so the bench retunes the write clock period to run faster, and later slower, than the 250 MHz read clock over several hundred characters. Idle characters are mixed in at one in three, so the block always has something it is allowed to drop or repeat. Recenters are provoked only after a long idle run has flushed every data character out of the store. Any non-IDLE character seen around a recenter is therefore a genuine loss or duplication, and the reference queue reports it.

// File: rtl/erb_pkg.sv
`timescale 1ns/1ps
// Shared types for the elastic receive buffer.
// Assumes: one character per entry; the idle flag alone decides whether an
// entry may be dropped or repeated.
package erb_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       idle;
        logic       kchar;
        logic       err;
    } erb_char_t;

    localparam erb_char_t ERB_IDLE_CHAR = '{data: 8'h00, idle: 1'b1, kchar: 1'b0, err: 1'b0};

endpackage

// File: rtl/erb_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a bus whose value changes in at most one bit per
// source cycle (Gray pointer or toggle flag).
// Assumes: the source holds each value for at least one destination cycle.
module erb_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/erb_gray2bin.sv
`timescale 1ns/1ps
// Combinational Gray-to-binary converter. Each binary bit is the XOR of all
// Gray bits at or above its position.
// Assumes: W >= 2.
module erb_gray2bin #(
    parameter int W = 5
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^(gray >> i);
    end
endmodule

// File: rtl/erb_wr_side.sv
`timescale 1ns/1ps
// Write domain of the elastic buffer: storage array, write pointer, deletion
// of IDLE characters on high fill, and the recenter request toggle.
// Assumes: one character arrives every wr_clk cycle; link events are
// single-cycle pulses; GUARD >= 4.
module erb_wr_side
    import erb_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int FILL_HI = 12,
    parameter int GUARD   = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  erb_char_t         in_char,
    input  logic              comma_realign,
    input  logic              sync_point,
    input  logic [ADDR_W:0]   rd_gray_sync,
    input  logic [ADDR_W-1:0] rd_addr,
    output erb_char_t         head_char,
    output logic [ADDR_W:0]   wr_gray,
    output logic              del_tgl,
    output logic              rc_tgl
);
    localparam int               DEPTH    = 1 << ADDR_W;
    localparam int               PW       = ADDR_W + 1;
    localparam int               RC_HOLD  = 3 * GUARD;
    localparam int               GW       = $clog2(RC_HOLD + 1);
    localparam logic [PW-1:0]    CENTER_P = PW'(DEPTH / 2);
    localparam logic [PW-1:0]    CENTER_G = CENTER_P ^ (CENTER_P >> 1);
    localparam logic [PW-1:0]    HI_P     = PW'(FILL_HI);
    localparam logic [GW-1:0]    GUARD_P  = GW'(GUARD - 1);
    localparam logic [GW-1:0]    RC_P     = GW'(RC_HOLD);

    erb_char_t     mem [DEPTH];
    logic [PW-1:0] wr_bin, wr_next, rd_bin, fill_w;
    logic [GW-1:0] guard;
    logic          rc_req, drop;

    erb_gray2bin #(.W(PW)) u_rd_g2b (.gray(rd_gray_sync), .bin(rd_bin));

    assign fill_w    = wr_bin - rd_bin;
    assign rc_req    = comma_realign | sync_point;
    assign drop      = in_char.idle && (fill_w > HI_P) && (guard == '0) && !rc_req;
    assign wr_next   = wr_bin + 1'b1;
    assign head_char = mem[rd_addr];

    // Store every character that is not dropped.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERB_IDLE_CHAR;
        end else if (!drop) begin
            mem[wr_bin[ADDR_W-1:0]] <= in_char;
        end
    end

    // Advance the write pointer and its Gray copy for each stored character.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_bin  <= CENTER_P;
            wr_gray <= CENTER_G;
        end else if (!drop) begin
            wr_bin  <= wr_next;
            wr_gray <= wr_next ^ (wr_next >> 1);
        end
    end

    // Flip the recenter and deletion toggles and pace deletions with a guard.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            rc_tgl  <= 1'b0;
            del_tgl <= 1'b0;
            guard   <= '0;
        end else if (rc_req) begin
            rc_tgl  <= ~rc_tgl;
            guard   <= RC_P;
        end else if (drop) begin
            del_tgl <= ~del_tgl;
            guard   <= GUARD_P;
        end else if (guard != '0) begin
            guard   <= guard - 1'b1;
        end
    end

    // A stored non-IDLE character advances the pointer by exactly one.
    assert_data_advance_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_rst_n && !in_char.idle) |=> (wr_bin == $past(wr_bin) + 1'b1));

    // The stored entry equals the character presented.
    assert_entry_kept_R1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_rst_n && !in_char.idle) |=> (mem[$past(wr_bin[ADDR_W-1:0])] == $past(in_char)));

    // A deletion only ever removes an IDLE seen while fill was above the limit.
    assert_del_cause_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (del_tgl != $past(del_tgl)) |-> ($past(in_char.idle) && ($past(fill_w) > HI_P)));

    // Successive deletions are at least four write cycles apart.
    assert_del_gap_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (del_tgl != $past(del_tgl)) |->
            (($past(del_tgl, 1) == $past(del_tgl, 2)) &&
             ($past(del_tgl, 2) == $past(del_tgl, 3)) &&
             ($past(del_tgl, 3) == $past(del_tgl, 4))));
endmodule

// File: rtl/erb_rd_side.sv
`timescale 1ns/1ps
// Read domain of the elastic buffer: read pointer, IDLE insertion on low
// fill, recenter of the read pointer, and the three event pulses.
// Assumes: the write-side toggles and Gray pointer arrive synchronised;
// GUARD >= 4.
module erb_rd_side
    import erb_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int FILL_LO = 4,
    parameter int GUARD   = 4
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [ADDR_W:0]   wr_gray_sync,
    input  logic              del_tgl_sync,
    input  logic              rc_tgl_sync,
    input  erb_char_t         head_char,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output erb_char_t         out_char,
    output logic              ins_pulse,
    output logic              del_pulse,
    output logic              recenter_pulse
);
    localparam int               DEPTH    = 1 << ADDR_W;
    localparam int               PW       = ADDR_W + 1;
    localparam int               GW       = $clog2(GUARD + 1);
    localparam logic [PW-1:0]    CENTER_P = PW'(DEPTH / 2);
    localparam logic [PW-1:0]    LO_P     = PW'(FILL_LO);
    localparam logic [GW-1:0]    GUARD_P  = GW'(GUARD - 1);

    logic [PW-1:0] wr_bin, rd_bin, rd_next, fill_r;
    logic [GW-1:0] guard;
    logic          rc_seen, del_seen, rc_now, ins_now;

    erb_gray2bin #(.W(PW)) u_wr_g2b (.gray(wr_gray_sync), .bin(wr_bin));

    assign fill_r  = wr_bin - rd_bin;
    assign rc_now  = rc_tgl_sync ^ rc_seen;
    assign ins_now = !rc_now && head_char.idle && (fill_r < LO_P) && (guard == '0);
    assign rd_addr = rd_bin[ADDR_W-1:0];

    // Choose the next read pointer: recenter, hold for insertion, or advance.
    always_comb begin
        if (rc_now)       rd_next = wr_bin - CENTER_P;
        else if (ins_now) rd_next = rd_bin;
        else              rd_next = rd_bin + 1'b1;
    end

    // Register the read pointer and its Gray copy.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_next;
            rd_gray <= rd_next ^ (rd_next >> 1);
        end
    end

    // Register the output character; a recenter cycle emits a clean IDLE.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) out_char <= ERB_IDLE_CHAR;
        else           out_char <= rc_now ? ERB_IDLE_CHAR : head_char;
    end

    // Edge-detect the toggles and produce the three event pulses.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rc_seen        <= 1'b0;
            del_seen       <= 1'b0;
            del_pulse      <= 1'b0;
            ins_pulse      <= 1'b0;
            recenter_pulse <= 1'b0;
        end else begin
            rc_seen        <= rc_tgl_sync;
            del_seen       <= del_tgl_sync;
            del_pulse      <= del_tgl_sync ^ del_seen;
            ins_pulse      <= ins_now;
            recenter_pulse <= rc_now;
        end
    end

    // Pace insertions; a recenter also restarts the guard.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)             guard <= '0;
        else if (rc_now || ins_now) guard <= GUARD_P;
        else if (guard != '0)      guard <= guard - 1'b1;
    end

    // The inserted character is always an IDLE.
    assert_ins_idle_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_pulse |-> out_char.idle);

    // An insertion leaves the read pointer where it was.
    assert_ins_hold_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_pulse |-> (rd_bin == $past(rd_bin)));

    // Successive insertions are at least four read cycles apart.
    assert_ins_gap_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_pulse |-> (!$past(ins_pulse, 1) && !$past(ins_pulse, 2) && !$past(ins_pulse, 3)));

    // A recenter cycle shows IDLE and never coincides with an insertion.
    assert_rc_idle_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        recenter_pulse |-> (out_char.idle && !ins_pulse));

    // The deletion report is a single-cycle pulse.
    assert_del_single_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        del_pulse |=> !del_pulse);
endmodule

// File: rtl/elastic_rx_buffer.sv
`timescale 1ns/1ps
// Top of the recentering elastic receive buffer. Connects the write domain,
// the read domain and the synchronizers that carry pointers and toggles
// between them.
// Assumes: the two resets are released together; link events are rare.
module elastic_rx_buffer #(
    parameter int ADDR_W  = 4,
    parameter int FILL_LO = 4,
    parameter int FILL_HI = 12,
    parameter int GUARD   = 4
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic [7:0] in_data,
    input  logic       in_idle,
    input  logic       in_kchar,
    input  logic       in_err,
    input  logic       comma_realign,
    input  logic       sync_point,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    output logic [7:0] out_data,
    output logic       out_idle,
    output logic       out_kchar,
    output logic       out_err,
    output logic       ins_pulse,
    output logic       del_pulse,
    output logic       recenter_pulse
);
    import erb_pkg::*;

    localparam int            PW       = ADDR_W + 1;
    localparam logic [PW-1:0] CENTER_P = PW'((1 << ADDR_W) / 2);
    localparam logic [PW-1:0] CENTER_G = CENTER_P ^ (CENTER_P >> 1);

    erb_char_t         in_char, head_char, out_char;
    logic [PW-1:0]     wr_gray, wr_gray_sync, rd_gray, rd_gray_sync;
    logic [ADDR_W-1:0] rd_addr;
    logic              del_tgl, rc_tgl, del_tgl_sync, rc_tgl_sync;

    assign in_char   = '{data: in_data, idle: in_idle, kchar: in_kchar, err: in_err};
    assign out_data  = out_char.data;
    assign out_idle  = out_char.idle;
    assign out_kchar = out_char.kchar;
    assign out_err   = out_char.err;

    erb_wr_side #(.ADDR_W(ADDR_W), .FILL_HI(FILL_HI), .GUARD(GUARD)) u_wr (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_char(in_char),
        .comma_realign(comma_realign), .sync_point(sync_point),
        .rd_gray_sync(rd_gray_sync), .rd_addr(rd_addr), .head_char(head_char),
        .wr_gray(wr_gray), .del_tgl(del_tgl), .rc_tgl(rc_tgl));

    erb_sync #(.W(PW), .RST_VAL(CENTER_G)) u_sync_wptr (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_sync));
    erb_sync #(.W(1)) u_sync_del (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(del_tgl), .q(del_tgl_sync));
    erb_sync #(.W(1)) u_sync_rc (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(rc_tgl), .q(rc_tgl_sync));
    erb_sync #(.W(PW)) u_sync_rptr (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_sync));

    erb_rd_side #(.ADDR_W(ADDR_W), .FILL_LO(FILL_LO), .GUARD(GUARD)) u_rd (
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .wr_gray_sync(wr_gray_sync),
        .del_tgl_sync(del_tgl_sync), .rc_tgl_sync(rc_tgl_sync),
        .head_char(head_char), .rd_addr(rd_addr), .rd_gray(rd_gray),
        .out_char(out_char), .ins_pulse(ins_pulse), .del_pulse(del_pulse),
        .recenter_pulse(recenter_pulse));
endmodule

// File: tb/tb_elastic_rx_buffer.sv
`timescale 1ns/1ps
// Self-checking bench: a queue holds every non-IDLE character in write order
// and is compared with the output on every read clock.
module tb_elastic_rx_buffer;
    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_idle = 1'b1, in_kchar = 1'b0, in_err = 1'b0;
    logic       comma_realign = 1'b0, sync_point = 1'b0;
    logic [7:0] out_data;
    logic       out_idle, out_kchar, out_err, ins_pulse, del_pulse, recenter_pulse;

    real        wr_half = 2.0;
    int         total = 0, bad = 0;
    int         ins_cnt = 0, del_cnt = 0, rc_cnt = 0, since_ins = 100, seq = 0;
    bit         mon_on = 1'b0;
    logic [9:0] exp_q [$];

    elastic_rx_buffer dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_data(in_data), .in_idle(in_idle),
        .in_kchar(in_kchar), .in_err(in_err), .comma_realign(comma_realign),
        .sync_point(sync_point), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .out_data(out_data), .out_idle(out_idle), .out_kchar(out_kchar),
        .out_err(out_err), .ins_pulse(ins_pulse), .del_pulse(del_pulse),
        .recenter_pulse(recenter_pulse));

    always #2.0 rd_clk = ~rd_clk;
    initial begin
        #0.7;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] d, input logic i, input logic k,
                         input logic e, input logic cm, input logic sp);
        @(negedge wr_clk);
        in_data = d; in_idle = i; in_kchar = k; in_err = e;
        comma_realign = cm; sync_point = sp;
    endtask

    task automatic send_stream(input int n);
        for (int j = 0; j < n; j++) begin
            logic [7:0] d;
            logic       i, k, e;
            d = seq[7:0];
            i = (seq % 3 == 2);
            k = (seq % 7 == 0);
            e = (seq % 11 == 0);
            if (!i) exp_q.push_back({d, k, e});
            drive(d, i, k, e, 1'b0, 1'b0);
            seq++;
        end
    endtask

    task automatic send_idles(input int n);
        for (int j = 0; j < n; j++) drive(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // Reference comparison and pulse bookkeeping on every read clock.
    always @(negedge rd_clk) begin
        if (mon_on) begin
            if (!out_idle) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "non-IDLE character with none expected",
                        int'({out_data, out_kchar, out_err}), -1);
                end else begin
                    chk({out_data, out_kchar, out_err} == exp_q[0], "R1 R3",
                        "character fields {data,k,err}",
                        int'({out_data, out_kchar, out_err}), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
            end
            if (ins_pulse) begin
                chk(out_idle == 1'b1, "R5", "inserted character idle flag", out_idle, 1);
                chk(since_ins >= 3, "R6", "read cycles between insertions", since_ins + 1, 4);
                ins_cnt++;
                since_ins = 0;
            end else begin
                since_ins++;
            end
            if (del_pulse) del_cnt++;
            if (recenter_pulse) begin
                chk(out_idle == 1'b1 && !ins_pulse, "R7", "idle output at recenter",
                    out_idle, 1);
                rc_cnt++;
            end
        end
    end

    initial begin
        int ins0, del0, rc0;
        repeat (8) @(negedge rd_clk);
        // R2: state during reset
        chk(out_idle == 1'b1, "R2", "out_idle in reset", out_idle, 1);
        chk(out_data == 8'h00 && !out_kchar && !out_err, "R2", "out fields in reset",
            int'({out_data, out_kchar, out_err}), 0);
        chk(!ins_pulse && !del_pulse && !recenter_pulse, "R2", "pulses in reset",
            int'({ins_pulse, del_pulse, recenter_pulse}), 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        // R2: stored entries start as IDLE after reset release
        chk(out_idle == 1'b1, "R2", "out_idle after release", out_idle, 1);
        chk(!ins_pulse && !del_pulse && !recenter_pulse, "R2", "pulses after release",
            int'({ins_pulse, del_pulse, recenter_pulse}), 0);
        mon_on = 1'b1;

        // Matched clocks: plain in-order delivery (R3)
        send_stream(300);
        send_idles(30);
        chk(exp_q.size() == 0, "R3", "undelivered characters, matched clocks",
            exp_q.size(), 0);
        chk(rc_cnt == 0, "R7", "recenters without event", rc_cnt, 0);

        // Fast write clock: deletions needed (R4, R9)
        del0 = del_cnt;
        wr_half = 1.9;
        send_stream(600);
        send_idles(30);
        chk(exp_q.size() == 0, "R9", "undelivered characters, fast write", exp_q.size(), 0);
        chk(del_cnt > del0, "R4", "deletions under fast write", del_cnt - del0, 1);

        // Slow write clock: insertions needed (R5, R9)
        ins0 = ins_cnt;
        wr_half = 2.125;
        send_stream(600);
        send_idles(30);
        chk(exp_q.size() == 0, "R9", "undelivered characters, slow write", exp_q.size(), 0);
        chk(ins_cnt > ins0, "R5", "insertions under slow write", ins_cnt - ins0, 1);

        // Comma realignment recenter (R7)
        wr_half = 2.0;
        send_idles(30);
        rc0 = rc_cnt;
        drive(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        send_idles(30);
        chk(rc_cnt == rc0 + 1, "R7", "recenters after comma realign", rc_cnt - rc0, 1);
        send_stream(150);
        send_idles(30);
        chk(exp_q.size() == 0, "R7", "undelivered after comma recenter", exp_q.size(), 0);

        // Word sync point recenter (R8)
        rc0 = rc_cnt;
        drive(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        send_idles(30);
        chk(rc_cnt == rc0 + 1, "R8", "recenters after sync point", rc_cnt - rc0, 1);
        send_stream(150);
        send_idles(30);
        chk(exp_q.size() == 0, "R8", "undelivered after sync recenter", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule